// File: doc/BRIEF.md
# Programmable SCL Timing Generator

This block produces the serial clock of a two-wire bus master from the system clock. A power-of-two prescaler divides the system clock into base ticks. Two four-bit phase counts then set how many base ticks SCL stays low and how many it stays high. All three values are decoded from one 32-bit timing word. Because each count starts from zero, a phase is never shorter than one base tick. With exponent B, low count L and high count H, one SCL period is 2^B × ((L+1) + (H+1)) system clocks.

The bus engine raises `run` to start clocking, which is the START point, and lowers it to stop. The generator drives SCL low for the low phase. It then releases the line and starts counting the high phase only once it observes SCL high, so a target that holds SCL low stretches the clock. Single-cycle strobes mark the end of each phase: `rise_tick` marks the last low cycle and `fall_tick` marks the last high cycle. The bus engine uses them to shift data. The timing fields are captured when clocking starts, so a register write never changes a byte that is already under way. Clearing `enable` returns all counters and the captured fields to zero.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, and whenever the generator is idle, `scl_pull_low`, `rise_tick`, `fall_tick` and `stretching` are all 0.
- R2: When `enable` and `run` are both 1 while idle, `scl_pull_low` becomes 1 in the next cycle. The low phase lasts (L+1)·2^B cycles, and `rise_tick` is 1 in its final cycle only.
- R3: After a low phase SCL is released. The high phase lasts (H+1)·2^B cycles counted from the first cycle SCL is seen high, and `fall_tick` is 1 in its final cycle. If still running, SCL is pulled low again in the next cycle. The two ticks are never 1 together.
- R4: In the timing word, B is bits 3:0 (any value 0 to 15), L is bits 15:12 and H is bits 19:16.
- R5: Bits 31:20 and 11:4 of the timing word have no effect on phase lengths.
- R6: In a high phase, while SCL has not yet been seen high and `scl_in` is 0, counting is paused and `stretching` is 1. The phase is lengthened by exactly the paused cycles.
- R7: The timing fields are captured in the cycle clocking starts. Changes to the timing word while running have no effect until `run` drops and rises again.
- R8: When `enable` is 0, SCL is released in the next cycle and the prescaler, phase counter and captured fields are cleared. The first low phase after re-enabling therefore has its full length.
- R9: When `run` is 0, SCL is released in the next cycle and the current phase is abandoned without a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Master enable; 0 clears all counters and captured fields |
| run | input | 1 | Bus engine request to generate SCL |
| timing_word | input | 32 | Timing register value holding B, L and H |
| scl_in | input | 1 | Sensed level of the SCL line |
| scl_pull_low | output | 1 | 1 drives SCL low, 0 releases it |
| rise_tick | output | 1 | Last cycle of a low phase |
| fall_tick | output | 1 | Last cycle of a high phase |
| stretching | output | 1 | Released SCL is being held low externally |

## Verification
Each `run` assertion has its first low cycle one clock later. Each tick falls in the final cycle of its phase, so the distance between successive ticks is exactly the phase length, plus any stall cycles in a stretched high phase. The scoreboard counts cycles at falling edges from the first low cycle and pops one expected phase length per tick, so a phase that is one cycle late or early is caught. Release after `run` or `enable` drops is checked at the falling edge that follows the next rising edge, which is the first cycle the idle state is visible.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } gen_state_e;

  // Terminal prescaler count for exponent b: 2^b - 1.
  function automatic logic [31:0] base_limit(logic [31:0] b);
    return (32'd1 << b) - 32'd1;
  endfunction

endpackage

// File: rtl/scl_field_decode.sv
module scl_field_decode #(
  parameter int WORD_W   = 32,
  parameter int BASE_W   = 4,
  parameter int FIELD_W  = 4,
  parameter int BASE_LSB = 0,
  parameter int LOW_LSB  = 12,
  parameter int HIGH_LSB = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               load,
  input  logic [WORD_W-1:0]  word,
  output logic [BASE_W-1:0]  base_q,
  output logic [FIELD_W-1:0] low_q,
  output logic [FIELD_W-1:0] high_q
);

  logic [BASE_W-1:0]  base_d;
  logic [FIELD_W-1:0] low_d;
  logic [FIELD_W-1:0] high_d;

  assign base_d = BASE_W'(word >> BASE_LSB);
  assign low_d  = FIELD_W'(word >> LOW_LSB);
  assign high_d = FIELD_W'(word >> HIGH_LSB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      low_q  <= '0;
      high_q <= '0;
    end else if (clr) begin
      base_q <= '0;
      low_q  <= '0;
      high_q <= '0;
    end else if (load) begin
      base_q <= base_d;
      low_q  <= low_d;
      high_q <= high_d;
    end
  end

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int BASE_W  = 4,
  parameter int PRESC_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic [BASE_W-1:0] base,
  output logic              tick
);

  logic [PRESC_W-1:0] cnt_q;
  logic [PRESC_W-1:0] limit;

  assign limit = PRESC_W'(scl_timing_pkg::base_limit(32'(base)));
  assign tick  = adv && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (tick)  cnt_q <= '0;
    else if (adv)   cnt_q <= cnt_q + PRESC_W'(1);
  end

endmodule

// File: rtl/scl_phase_counter.sv
module scl_phase_counter #(
  parameter int FIELD_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               adv,
  input  logic [FIELD_W-1:0] limit,
  output logic               done
);

  logic [FIELD_W-1:0] cnt_q;

  assign done = adv && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (done)  cnt_q <= '0;
    else if (adv)   cnt_q <= cnt_q + FIELD_W'(1);
  end

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_timing_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int BASE_W   = 4,
  parameter int FIELD_W  = 4,
  parameter int BASE_LSB = 0,
  parameter int LOW_LSB  = 12,
  parameter int HIGH_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              run,
  input  logic [WORD_W-1:0] timing_word,
  input  logic              scl_in,
  output logic              scl_pull_low,
  output logic              rise_tick,
  output logic              fall_tick,
  output logic              stretching
);

  localparam int PRESC_W = (1 << BASE_W) - 1;

  gen_state_e         state_q, state_d;
  logic               seen_high_q;
  logic               go, in_low, in_high, start_ev;
  logic               high_run, presc_adv, cnt_clr;
  logic               presc_tick, phase_end;
  logic               gen_active;
  logic [BASE_W-1:0]  cfg_base_q;
  logic [FIELD_W-1:0] cfg_low_q, cfg_high_q, phase_limit;

  assign go         = enable && run;
  assign in_low     = (state_q == ST_LOW);
  assign in_high    = (state_q == ST_HIGH);
  assign gen_active = (state_q != ST_IDLE);
  assign start_ev   = go && !gen_active;
  assign high_run   = in_high && (scl_in || seen_high_q);
  assign presc_adv  = in_low || high_run;
  assign cnt_clr    = !go || !gen_active;
  assign phase_limit = in_high ? cfg_high_q : cfg_low_q;

  scl_field_decode #(
    .WORD_W(WORD_W), .BASE_W(BASE_W), .FIELD_W(FIELD_W),
    .BASE_LSB(BASE_LSB), .LOW_LSB(LOW_LSB), .HIGH_LSB(HIGH_LSB)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .clr(!enable), .load(start_ev),
    .word(timing_word), .base_q(cfg_base_q), .low_q(cfg_low_q), .high_q(cfg_high_q)
  );

  scl_prescaler #(.BASE_W(BASE_W), .PRESC_W(PRESC_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .adv(presc_adv),
    .base(cfg_base_q), .tick(presc_tick)
  );

  scl_phase_counter #(.FIELD_W(FIELD_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .adv(presc_tick),
    .limit(phase_limit), .done(phase_end)
  );

  assign rise_tick    = in_low && phase_end;
  assign fall_tick    = in_high && phase_end;
  assign stretching   = in_high && !scl_in && !seen_high_q;
  assign scl_pull_low = in_low;

  always_comb begin
    state_d = state_q;
    if (!go) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: state_d = ST_LOW;
        ST_LOW:  if (rise_tick) state_d = ST_HIGH;
        ST_HIGH: if (fall_tick) state_d = ST_LOW;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      seen_high_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (!go || fall_tick)        seen_high_q <= 1'b0;
      else if (in_high && scl_in)  seen_high_q <= 1'b1;
    end
  end

endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk #(
  parameter int CFG_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             run,
  input logic             scl_in,
  input logic             scl_pull_low,
  input logic             rise_tick,
  input logic             fall_tick,
  input logic             stretching,
  input logic             gen_active,
  input logic [CFG_W-1:0] cfg_snap
);

  // R3
  ticks_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_tick && fall_tick));

  // R2
  rise_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick |-> scl_pull_low);

  // R2
  start_pulls_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && enable && !gen_active) |=> scl_pull_low);

  // R3
  rise_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick |=> !scl_pull_low);

  // R3
  fall_relowers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_tick && run && enable) |=> scl_pull_low);

  // R6
  stretch_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stretching |-> (!scl_in && !scl_pull_low && !fall_tick));

  // R9
  run_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!scl_pull_low && !rise_tick && !fall_tick));

  // R8
  disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_pull_low && !stretching && !gen_active));

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_active && $past(gen_active)) |-> $stable(cfg_snap));

endmodule

bind scl_timing_gen scl_timing_gen_chk #(.CFG_W(BASE_W + 2 * FIELD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .run(run), .scl_in(scl_in),
  .scl_pull_low(scl_pull_low), .rise_tick(rise_tick), .fall_tick(fall_tick),
  .stretching(stretching), .gen_active(gen_active),
  .cfg_snap({cfg_base_q, cfg_low_q, cfg_high_q})
);

// File: tb/scl_timing_gen_test.sv
module scl_timing_gen_test;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit    is_rise;
    int    len;
    string req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        run = 1'b0;
  logic [31:0] timing_word = '0;
  logic        slave_hold = 1'b0;
  logic        scl_in;
  logic        scl_pull_low, rise_tick, fall_tick, stretching;

  int   n_checks = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;
  exp_t exp_q[$];
  int   mon_cnt = 0;
  bit   mon_started = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign scl_in = !(scl_pull_low || slave_hold);

  scl_timing_gen uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .run(run),
    .timing_word(timing_word), .scl_in(scl_in), .scl_pull_low(scl_pull_low),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .stretching(stretching)
  );

  task automatic chk(bit ok, string req, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int phase_len(int field, int b);
    int n = field + 1;
    for (int i = 0; i < b; i++) n = n * 2;
    return n;
  endfunction

  function automatic logic [31:0] mk_word(int b, int l, int h, logic [31:0] junk);
    logic [31:0] w = junk;
    w[3:0]   = 4'(b);
    w[15:12] = 4'(l);
    w[19:16] = 4'(h);
    return w;
  endfunction

  task automatic push(bit is_rise, int len, string req);
    exp_t e;
    e.is_rise = is_rise;
    e.len = len;
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic set_run(bit v);
    @(posedge clk);
    #1 run = v;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic idle_check(string req);
    @(posedge clk);
    @(negedge clk);
    chk(!scl_pull_low && !rise_tick && !fall_tick && !stretching, req, int'(scl_pull_low), 0);
  endtask

  task automatic burst(int b, int l, int h, logic [31:0] junk, int nph, string req);
    timing_word = mk_word(b, l, h, junk);
    for (int i = 0; i < nph; i++) begin
      if (i % 2 == 0) push(1'b1, phase_len(l, b), req);
      else            push(1'b0, phase_len(h, b), req);
    end
    set_run(1'b1);
    drain();
    set_run(1'b0);
    idle_check("R9");
  endtask

  // Monitor: counts cycles of each phase and compares at every tick.
  always @(negedge clk) begin
    if (!rst_n || !run || !enable) begin
      mon_cnt = 0;
      mon_started = 1'b0;
    end else begin
      if (scl_pull_low) mon_started = 1'b1;
      if (mon_started) mon_cnt++;
      if (rise_tick || fall_tick) begin
        if (exp_q.size() > 0) begin
          exp_t e;
          e = exp_q.pop_front();
          chk((e.is_rise == rise_tick) && (mon_cnt == e.len),
              {e.req, rise_tick ? " low-phase" : " high-phase"}, mon_cnt, e.len);
        end
        mon_cnt = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state
    @(negedge clk);
    chk(!scl_pull_low && !rise_tick && !fall_tick && !stretching, "R1", int'(scl_pull_low), 0);
    @(posedge clk);
    #1 enable = 1'b1;
    repeat (3) @(negedge clk);
    chk(!scl_pull_low && !rise_tick && !fall_tick, "R1 enabled idle", int'(scl_pull_low), 0);

    // R2 R3: minimum phases
    burst(0, 0, 0, 32'h0, 4, "R2/R3 min");
    // R4: distinct low/high fields with prescaler
    burst(2, 3, 1, 32'h0, 4, "R4 b2l3h1");
    burst(1, 15, 15, 32'h0, 2, "R4 max fields");
    // R5: ignored bits set
    burst(2, 3, 1, 32'hABC0_0FF0, 4, "R5");

    // R6: stretched first high phase
    timing_word = mk_word(1, 1, 2, 32'h0);
    slave_hold = 1'b1;
    push(1'b1, phase_len(1, 1), "R6");
    push(1'b0, 5 + phase_len(2, 1), "R6 stretched");
    push(1'b1, phase_len(1, 1), "R6");
    push(1'b0, phase_len(2, 1), "R6 normal");
    set_run(1'b1);
    @(negedge clk);
    while (!stretching) @(negedge clk);
    chk(!scl_pull_low && stretching, "R6 stretching flag", int'(stretching), 1);
    repeat (5) @(posedge clk);
    #1 slave_hold = 1'b0;
    drain();
    set_run(1'b0);
    idle_check("R9");

    // R7: change while running is ignored, applied on restart
    timing_word = mk_word(0, 2, 3, 32'h0);
    push(1'b1, 3, "R7 old");
    push(1'b0, 4, "R7 old");
    push(1'b1, 3, "R7 old");
    push(1'b0, 4, "R7 old");
    set_run(1'b1);
    @(negedge clk);
    while (!rise_tick) @(negedge clk);
    @(posedge clk);
    #1 timing_word = mk_word(1, 0, 0, 32'h0);
    drain();
    set_run(1'b0);
    idle_check("R9");
    push(1'b1, 2, "R7 new");
    push(1'b0, 2, "R7 new");
    set_run(1'b1);
    drain();
    set_run(1'b0);
    idle_check("R9");

    // R8: disable mid low phase, then full-length restart
    timing_word = mk_word(2, 1, 1, 32'h0);
    set_run(1'b1);
    repeat (3) @(posedge clk);
    #1 enable = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(!scl_pull_low && !rise_tick && !fall_tick, "R8 released", int'(scl_pull_low), 0);
    push(1'b1, 8, "R8 full restart");
    push(1'b0, 8, "R8 full restart");
    @(posedge clk);
    #1 enable = 1'b1;
    drain();
    set_run(1'b0);
    idle_check("R9");

    // R9: run dropped mid low phase
    timing_word = mk_word(3, 0, 0, 32'h0);
    set_run(1'b1);
    repeat (3) @(posedge clk);
    #1 run = 1'b0;
    @(posedge clk);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(!scl_pull_low && !rise_tick && !fall_tick, "R9 abandoned phase", int'(scl_pull_low), 0);
    end

    // R4: largest exponent
    timing_word = mk_word(15, 0, 0, 32'h0);
    push(1'b1, phase_len(0, 15), "R4 max base");
    set_run(1'b1);
    drain();
    set_run(1'b0);
    idle_check("R9");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule